// File: doc/BRIEF.md
# Cascadable Magnitude Comparator

This block compares two unsigned operands and raises exactly one of three flags: greater, equal or less. The basic element is a 4-bit slice. Each slice takes a three-line verdict from its less significant neighbour and produces a three-line verdict for its more significant neighbour.

A slice whose own operand nibbles differ decides the verdict from its own bits. The incoming verdict plays no part in that case. When the nibbles match, the slice forwards the incoming verdict unchanged.

The top level chains a parameterised number of slices. Slice 0 takes the least significant nibble and has its incoming verdict tied to "equal". The final flags come from the most significant slice. The whole path is combinational, with no clock and no storage. With the default of three slices it forms a 12-bit comparator.

Top module: `mag_cmp_chain`

## Requirements
- R1: `res_gt` is 1 exactly when `opa` > `opb`, with both operands taken as unsigned numbers of NSLICE*SLICE_W bits.
- R2: `res_eq` is 1 exactly when `opa` equals `opb`.
- R3: `res_lt` is 1 exactly when `opa` < `opb`.
- R4: For every operand pair, exactly one of `res_gt`, `res_eq` and `res_lt` is 1.
- R5: When a slice's two operand nibbles differ, its outgoing verdict depends only on those nibbles. Any legal incoming verdict (gt, eq or lt, one-hot) is ignored.
- R6: When a slice's two operand nibbles are equal, its outgoing verdict equals its incoming verdict. Bit 2 of the verdict is gt, bit 1 is eq and bit 0 is lt.
- R7: A difference in a more significant bit or slice decides the result, whatever the less significant bits hold.
- R8: The least significant slice sees an incoming verdict of "equal". With NSLICE=1, the flags therefore match a plain 4-bit unsigned comparison for all 256 operand pairs.
- R9: Slice k compares operand bits [4k+3:4k]. Verdicts travel from slice 0 up to slice NSLICE-1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa | input | NSLICE*SLICE_W | First unsigned operand |
| opb | input | NSLICE*SLICE_W | Second unsigned operand |
| res_gt | output | 1 | opa is greater than opb |
| res_eq | output | 1 | opa equals opb |
| res_lt | output | 1 | opa is less than opb |

## Verification
The hardest case to reach from the chain's ports is a single slice that must override a conflicting incoming verdict. It only arises when a lower nibble disagrees with a higher one, and random wide operands seldom line up that way.

The bench therefore drives a standalone slice with all 256 nibble pairs under each of the three legal incoming verdicts. It also builds chained operands directly, making the top nibbles differ while the lower nibbles point the opposite way, or matching in every slice except one.

// File: rtl/cmp_pkg.sv
package cmp_pkg;
    // Three-line verdict carried between slices: bit 2 gt, bit 1 eq, bit 0 lt.
    typedef struct packed {
        logic gt;
        logic eq;
        logic lt;
    } verdict_t;

    localparam verdict_t VERDICT_EQ = '{gt: 1'b0, eq: 1'b1, lt: 1'b0};
endpackage

// File: rtl/mag_cmp_bitcell.sv
module mag_cmp_bitcell (
    input  logic a_bit,
    input  logic b_bit,
    output logic bit_gt,
    output logic bit_eq
);
    assign bit_gt = a_bit & ~b_bit;
    assign bit_eq = ~(a_bit ^ b_bit);
endmodule

// File: rtl/mag_cmp_slice.sv
module mag_cmp_slice
    import cmp_pkg::*;
#(
    parameter int SLICE_W = 4
) (
    input  logic [SLICE_W-1:0] a_nib,
    input  logic [SLICE_W-1:0] b_nib,
    input  verdict_t           v_in,
    output verdict_t           v_out
);
    logic [SLICE_W-1:0] bgt;
    logic [SLICE_W-1:0] beq;

    for (genvar i = 0; i < SLICE_W; i++) begin : g_bit
        mag_cmp_bitcell u_cell (
            .a_bit  (a_nib[i]),
            .b_bit  (b_nib[i]),
            .bit_gt (bgt[i]),
            .bit_eq (beq[i])
        );
    end

    // Scan from the most significant bit: the first differing bit decides.
    always_comb begin
        logic above_eq;
        logic win;
        logic lose;
        above_eq = 1'b1;
        win      = 1'b0;
        lose     = 1'b0;
        for (int i = SLICE_W - 1; i >= 0; i--) begin
            win      = win  | (above_eq & bgt[i]);
            lose     = lose | (above_eq & ~beq[i] & ~bgt[i]);
            above_eq = above_eq & beq[i];
        end
        v_out.gt = win  | (above_eq & v_in.gt);
        v_out.eq = above_eq & v_in.eq;
        v_out.lt = lose | (above_eq & v_in.lt);
    end
endmodule

// File: rtl/mag_cmp_chain.sv
module mag_cmp_chain
    import cmp_pkg::*;
#(
    parameter int NSLICE  = 3,
    parameter int SLICE_W = 4
) (
    input  logic [NSLICE*SLICE_W-1:0] opa,
    input  logic [NSLICE*SLICE_W-1:0] opb,
    output logic                      res_gt,
    output logic                      res_eq,
    output logic                      res_lt
);
    localparam int TOT_W = NSLICE * SLICE_W;

    for (genvar s = 0; s < NSLICE; s++) begin : g_sl
        verdict_t vin_w;
        verdict_t vout_w;
        if (s == 0) begin : g_first
            assign vin_w = VERDICT_EQ;
        end else begin : g_next
            assign vin_w = g_sl[s-1].vout_w;
        end
        mag_cmp_slice #(.SLICE_W(SLICE_W)) u_slice (
            .a_nib (opa[s*SLICE_W +: SLICE_W]),
            .b_nib (opb[s*SLICE_W +: SLICE_W]),
            .v_in  (vin_w),
            .v_out (vout_w)
        );
    end

    assign res_gt = g_sl[NSLICE-1].vout_w.gt;
    assign res_eq = g_sl[NSLICE-1].vout_w.eq;
    assign res_lt = g_sl[NSLICE-1].vout_w.lt;
endmodule

// File: rtl/mag_cmp_chain_chk.sv
module mag_cmp_chain_chk #(
    parameter int TOT_W = 12
) (
    input logic [TOT_W-1:0] opa,
    input logic [TOT_W-1:0] opb,
    input logic             res_gt,
    input logic             res_eq,
    input logic             res_lt
);
    always_comb begin
        a_r4_one_flag: assert ($countones({res_gt, res_eq, res_lt}) == 1);
        a_r1_gt_flag:  assert (res_gt == (opa > opb));
        a_r2_eq_flag:  assert (res_eq == (opa == opb));
        a_r3_lt_flag:  assert (res_lt == (opa < opb));
    end
endmodule

bind mag_cmp_chain mag_cmp_chain_chk #(.TOT_W(TOT_W)) u_chk (
    .opa    (opa),
    .opb    (opb),
    .res_gt (res_gt),
    .res_eq (res_eq),
    .res_lt (res_lt)
);

// File: tb/mag_cmp_chain_tb.sv
module mag_cmp_chain_tb;
    import cmp_pkg::*;

    localparam int CLK_P = 10;
    localparam int NS    = 3;
    localparam int SW    = 4;
    localparam int TW    = NS * SW;

    logic clk = 1'b0;
    always #(CLK_P/2) clk = ~clk;

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;
    bit done   = 1'b0;

    logic [TW-1:0] a12, b12;
    logic          g12, e12, l12;
    logic [SW-1:0] a4, b4;
    logic          g4, e4, l4;
    logic [SW-1:0] sa, sb;
    verdict_t      sin, sout;

    mag_cmp_chain #(.NSLICE(NS), .SLICE_W(SW)) u_dut (
        .opa(a12), .opb(b12), .res_gt(g12), .res_eq(e12), .res_lt(l12));
    mag_cmp_chain #(.NSLICE(1), .SLICE_W(SW)) u_one (
        .opa(a4), .opb(b4), .res_gt(g4), .res_eq(e4), .res_lt(l4));
    mag_cmp_slice #(.SLICE_W(SW)) u_slice (
        .a_nib(sa), .b_nib(sb), .v_in(sin), .v_out(sout));

    task automatic check(input string req, input logic [2:0] act, input logic [2:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%b exp=%b", req, act, exp);
        end
    endtask

    function automatic logic [2:0] ref3(input logic [TW-1:0] a, input logic [TW-1:0] b);
        return {a > b, a == b, a < b};
    endfunction

    task automatic wide(input string req, input logic [TW-1:0] a, input logic [TW-1:0] b);
        @(negedge clk);
        a12 = a; b12 = b;
        #(CLK_P/4);
        check(req, {g12, e12, l12}, ref3(a, b));
        check("R4", {2'b0, ($countones({g12, e12, l12}) == 1)}, 3'b001);
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000 && !done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog act=%0d exp<150000", cyc);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        a12 = '0; b12 = '0; a4 = '0; b4 = '0; sa = '0; sb = '0; sin = VERDICT_EQ;
        #(CLK_P/4);
        // reset-state / idle inputs: zero operands compare equal
        check("R2 idle", {g12, e12, l12}, 3'b010);

        // R8: single slice with tied equal cascade, all 256 pairs
        for (int i = 0; i < 16; i++) begin
            for (int j = 0; j < 16; j++) begin
                @(negedge clk);
                a4 = SW'(i); b4 = SW'(j);
                #(CLK_P/4);
                check("R8", {g4, e4, l4}, {i > j, i == j, i < j});
            end
        end

        // R5 / R6: standalone slice under each legal incoming verdict
        for (int c = 0; c < 3; c++) begin
            for (int i = 0; i < 16; i++) begin
                for (int j = 0; j < 16; j++) begin
                    logic [2:0] cv;
                    cv = 3'b100 >> c;
                    @(negedge clk);
                    sa = SW'(i); sb = SW'(j); sin = cv;
                    #(CLK_P/4);
                    if (i == j) check("R6", sout, cv);
                    else        check("R5", sout, {i > j, 1'b0, i < j});
                end
            end
        end

        // R7: top nibble decides, lower nibbles point the other way
        wide("R7", 12'h100, 12'h0FF);
        wide("R7", 12'h0FF, 12'h100);
        wide("R7", 12'h800, 12'h7FF);
        wide("R7", 12'h7FF, 12'h800);
        // R9: equal everywhere except one slice
        for (int s = 0; s < NS; s++) begin
            wide("R9", 12'hA5C ^ (TW'(1) << (s*SW)), 12'hA5C);
            wide("R9", 12'hA5C, 12'hA5C ^ (TW'(1) << (s*SW)));
        end
        wide("R2", 12'hFFF, 12'hFFF);
        wide("R1", 12'hFFF, 12'h000);
        wide("R3", 12'h000, 12'hFFF);

        // R1 / R2 / R3: random wide pairs, some forced equal
        for (int k = 0; k < 2000; k++) begin
            logic [TW-1:0] ra, rb;
            ra = TW'($urandom);
            rb = (k % 5 == 0) ? ra : TW'($urandom);
            if (k % 7 == 0) rb = {ra[TW-1:SW], rb[SW-1:0]};
            wide("R1/R2/R3", ra, rb);
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule